// File: doc/BRIEF.md
# Parallel Rule 110 Cell Array

This block holds a one-dimensional row of binary cells. On every clock cycle it computes the next generation of all cells at once, using the elementary automaton rule numbered 110. Each cell's new value depends on three cells: the cell to its left, the cell itself and the cell to its right. After reset the row contains a single one in its rightmost position. The row then starts evolving immediately.

Software reaches the row through a byte-wide port that selects one block at a time. A block is eight cells, and blocks are counted from the right-hand end. The read bus shows the selected block combinationally. Driving the active-low halt input low freezes the row. While the row is frozen, an active-low write strobe replaces the selected block on the next clock edge. This lets the array be inspected one generation at a time, or loaded with any starting pattern.

Top module: `r110_array`

## Requirements
- R1: While `halt_ni` is high and `rst_ni` is high, every clock edge replaces all cells with their Rule 110 successor. A cell with neighbourhood (left, self, right) becomes 1 for the patterns 110, 101, 011, 010 and 001. It becomes 0 for the patterns 111, 100 and 000.
- R2: While `rst_ni` is low, cell 0 (the rightmost cell) is 1 and every other cell is 0.
- R3: Positions beyond either end of the row count as 0 when the neighbourhoods of the two end cells are formed.
- R4: While `halt_ni` is low and `we_ni` is high, the cell state does not change.
- R5: Cell 8*b+k belongs to block b and appears on `rdata_o[k]` while `addr_i` equals b. Bit 0 is the rightmost cell of the block. The output follows `addr_i` with no clock delay.
- R6: At a clock edge where `halt_ni` is low, `we_ni` is low and `addr_i` selects an existing block, that block's eight cells take the value of `wdata_i`. All other cells keep their values.
- R7: At a clock edge where `halt_ni` is high, `we_ni` has no effect, and the row evolves as in R1.
- R8: If `addr_i` is NUM_BLK or higher, `rdata_o` reads 0, and a write to that address changes no cell.
- R9: Starting from the reset seed, after ten generations block 0 reads 0x0D and block 1 reads 0x07.
- R10: An all-zero row stays all-zero while it evolves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; loads the seed |
| wdata_i | input | 8 | Data for a block write |
| we_ni | input | 1 | Block write strobe, active low; takes effect only while halted |
| halt_ni | input | 1 | Evolution enable; low freezes the row |
| addr_i | input | 5 | Block select, block 0 is the rightmost |
| rdata_o | output | 8 | Cells of the selected block, bit 0 rightmost |

## Verification
The single-one reset seed is evolved for several hundred generations. This shows that the rule table is correct and that the pattern grows leftward until it hits the left edge, which exercises the left boundary. Next, hand-picked blocks are preloaded, including ones in the rightmost block and in the leftmost block. Evolving these patterns exercises both boundaries and triplet combinations that the seed does not produce early on. Writes at addresses past the last block, and write strobes applied while the row is running, must leave the model and the design in agreement. This separates correct address decoding and halt gating from errors there. Finally, an all-zero row shows that no cell is ever set spuriously.

// File: rtl/r110_pkg.sv
`timescale 1ns/100ps
package r110_pkg;
  localparam int          BLK_W    = 8;
  localparam logic [7:0]  RULE_TAB = 8'd110;  // indexed by {left,self,right}
endpackage

// File: rtl/r110_next_state.sv
`timescale 1ns/100ps
module r110_next_state
  import r110_pkg::*;
#(
  parameter int NUM_CELLS = 120
) (
  input  logic [NUM_CELLS-1:0] cells_i,
  output logic [NUM_CELLS-1:0] next_o
);
  // cell 0 is the rightmost; index i+1 is the left neighbour
  logic [NUM_CELLS+1:0] ext;
  assign ext = {1'b0, cells_i, 1'b0};

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    assign next_o[i] = RULE_TAB[ext[i+2:i]];
  end

  always_comb begin
    if (cells_i[1:0] == 2'b00)
      AST_RIGHT_EDGE_ZERO: assert (next_o[0] == 1'b0); // R3
  end
endmodule

// File: rtl/r110_blk_write.sv
`timescale 1ns/100ps
module r110_blk_write
  import r110_pkg::*;
#(
  parameter int NUM_BLK = 15,
  parameter int ADDR_W  = 5,
  localparam int NUM_CELLS = NUM_BLK * BLK_W
) (
  input  logic [NUM_CELLS-1:0] cells_i,
  input  logic [NUM_CELLS-1:0] evolved_i,
  input  logic                 halt_ni,
  input  logic                 we_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BLK_W-1:0]     wdata_i,
  output logic [NUM_CELLS-1:0] cells_d_o
);
  logic [NUM_BLK-1:0] blk_sel;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blk_sel[b] = !halt_ni && !we_ni && (addr_i == ADDR_W'(b));
    assign cells_d_o[b*BLK_W +: BLK_W] =
        halt_ni    ? evolved_i[b*BLK_W +: BLK_W] :
        blk_sel[b] ? wdata_i :
                     cells_i[b*BLK_W +: BLK_W];
  end

  always_comb begin
    AST_ONE_BLOCK_SEL: assert ($onehot0(blk_sel)); // R6
  end
endmodule

// File: rtl/r110_rd_mux.sv
`timescale 1ns/100ps
module r110_rd_mux
  import r110_pkg::*;
#(
  parameter int NUM_BLK = 15,
  parameter int ADDR_W  = 5,
  localparam int NUM_CELLS = NUM_BLK * BLK_W
) (
  input  logic [NUM_CELLS-1:0] cells_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [BLK_W-1:0]     rdata_o
);
  logic [NUM_BLK-1:0][BLK_W-1:0] blk;
  logic [NUM_BLK-1:0]            hit;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blk[b] = cells_i[b*BLK_W +: BLK_W];
    assign hit[b] = (addr_i == ADDR_W'(b));
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BLK; b++)
      if (hit[b]) rdata_o = rdata_o | blk[b];
  end
endmodule

// File: rtl/r110_array.sv
`timescale 1ns/100ps
module r110_array
  import r110_pkg::*;
#(
  parameter int NUM_BLK = 15,
  parameter int ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  wdata_i,
  input  logic              we_ni,
  input  logic              halt_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BLK_W-1:0]  rdata_o
);
  localparam int               NUM_CELLS = NUM_BLK * BLK_W;
  localparam logic [ADDR_W:0]  BLK_LIM   = (ADDR_W+1)'(NUM_BLK);

  logic [NUM_CELLS-1:0] cells_q, cells_d, evolved;

  r110_next_state #(.NUM_CELLS(NUM_CELLS)) u_next (
    .cells_i (cells_q),
    .next_o  (evolved)
  );

  r110_blk_write #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W)) u_wr (
    .cells_i   (cells_q),
    .evolved_i (evolved),
    .halt_ni   (halt_ni),
    .we_ni     (we_ni),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cells_d_o (cells_d)
  );

  r110_rd_mux #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W)) u_rd (
    .cells_i (cells_q),
    .addr_i  (addr_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cells_q <= NUM_CELLS'(1);
    else         cells_q <= cells_d;
  end

  logic addr_ok;
  assign addr_ok = {1'b0, addr_i} < BLK_LIM;

  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_ni && (cells_q == '0) |=> (cells_q == '0)); // R10
  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_ni && we_ni |=> $stable(cells_q)); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_ni && !we_ni && addr_ok
    |=> cells_q[$past(addr_i)*BLK_W +: BLK_W] == $past(wdata_i)); // R6
  AST_OOR_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_ni && !addr_ok |=> $stable(cells_q)); // R8
  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_ok |-> rdata_o == '0); // R8
endmodule

// File: tb/sim_r110_array.sv
`timescale 1ns/100ps
module sim_r110_array;
  localparam int  CLK_PERIOD = 10;
  localparam int  NB = 15;
  localparam int  NC = NB * 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       we_ni = 1'b1;
  logic       halt_ni = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] rdata_o;

  int n_run = 0;
  int n_fail = 0;
  logic [NC-1:0] m;

  r110_array #(.NUM_BLK(NB), .ADDR_W(5)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdata_i(wdata_i), .we_ni(we_ni),
    .halt_ni(halt_ni), .addr_i(addr_i), .rdata_o(rdata_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [NC-1:0] evolve(input logic [NC-1:0] c);
    logic [NC-1:0] n;
    for (int i = 0; i < NC; i++) begin
      logic l, s, r;
      l = (i == NC-1) ? 1'b0 : c[i+1];
      s = c[i];
      r = (i == 0) ? 1'b0 : c[i-1];
      n[i] = (s ^ r) | (s & r & ~l);
    end
    return n;
  endfunction

  task automatic check8(input string req, input int a, input logic [7:0] exp);
    n_run++;
    if (rdata_o !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rdata_o, exp);
    end
  endtask

  // reads every address, in range and past the end (R5, R8)
  task automatic sweep(input string req);
    for (int b = 0; b < 32; b++) begin
      addr_i = 5'(b);
      #0.1;
      check8(req, b, (b < NB) ? m[b*8 +: 8] : 8'h00);
    end
  endtask

  task automatic step(input logic h, input logic w, input int a,
                      input logic [7:0] d, input string req);
    halt_ni = h; we_ni = w; addr_i = 5'(a); wdata_i = d;
    @(posedge clk_i);
    if (h) m = evolve(m);
    else if (!w && a < NB) m[a*8 +: 8] = d;
    #1;
    sweep(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m = NC'(1);
    #(CLK_PERIOD * 2 + 1);
    sweep("R2_reset_seed");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 1, 0, 8'h00, "R2_seed_held");

    // R9: ten generations from the seed
    for (int g = 0; g < 10; g++) step(1, 1, 0, 8'h00, "R1_seed_run");
    @(negedge clk_i);
    halt_ni = 1'b0;
    addr_i = 5'd0; #0.1; check8("R9_gen10_blk0", 0, 8'h0D);
    addr_i = 5'd1; #0.1; check8("R9_gen10_blk1", 1, 8'h07);

    // R1, R3: grow until the pattern meets the left edge
    for (int g = 0; g < 300; g++) step(1, 1, 0, 8'h00, "R1_R3_long_run");

    // R4: frozen while halted
    for (int g = 0; g < 4; g++) step(0, 1, 3, 8'hAA, "R4_halt_freeze");

    // R6: preload blocks, idle cycle between writes
    step(0, 0, 0, 8'h07, "R6_write_blk0"); step(0, 1, 0, 8'h00, "R6_idle");
    step(0, 0, 1, 8'hE6, "R6_write_blk1"); step(0, 1, 0, 8'h00, "R6_idle");
    step(0, 0, 2, 8'hD7, "R6_write_blk2"); step(0, 1, 0, 8'h00, "R6_idle");
    step(0, 0, NB-1, 8'h81, "R6_R3_write_top"); step(0, 1, 0, 8'h00, "R6_idle");
    for (int b = 3; b < NB-1; b++) begin
      step(0, 0, b, 8'(b * 37 + 11), "R6_write_mid");
      step(0, 1, 0, 8'h00, "R6_idle");
    end

    // R8: writes past the last block
    step(0, 0, NB, 8'hFF, "R8_oor_write");
    step(0, 0, 31, 8'h5A, "R8_oor_write_max");

    // R7: write strobe while running is ignored
    for (int g = 0; g < 6; g++) step(1, 0, g, 8'hFF, "R7_we_while_run");

    for (int g = 0; g < 200; g++) step(1, 1, 0, 8'h00, "R1_R3_preload_run");

    // R3: ones on both ends
    step(0, 0, 0, 8'h01, "R3_right_edge"); step(0, 1, 0, 8'h00, "R6_idle");
    step(0, 0, NB-1, 8'h80, "R3_left_edge"); step(0, 1, 0, 8'h00, "R6_idle");
    for (int g = 0; g < 20; g++) step(1, 1, 0, 8'h00, "R3_edge_run");

    // R10: all-zero row
    for (int b = 0; b < NB; b++) begin
      step(0, 0, b, 8'h00, "R6_clear");
      step(0, 1, 0, 8'h00, "R6_idle");
    end
    for (int g = 0; g < 8; g++) step(1, 1, 0, 8'h00, "R10_zero_fixed");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule